// File: doc/BRIEF.md
# Triggered String Readout Sequencer

This block sequences one readout of eight front-end amplifier strings in the acquisition and test modes. It stays idle while the serial transmitter reports that it is busy. After that it arms on a first-level trigger. This trigger is an active-low line, and it must stay low long enough to pass a glitch filter. The block then opens a fixed window for the second-level trigger, which is active high. If the second trigger does not arrive within the window, the block re-arms on its own.

When the second trigger is accepted, the block raises its busy flag. It then generates the front-end readout clock at one sixteenth of the system clock for 768 channels. All strings are clocked together, so the longest string sets the readout time. A shift token marks the first channel. FIFO write strobes lag the channel clocks by a fixed number of readout periods to cover the converter's pipeline latency.

After the last sample is written, the block waits for the downstream bus to be free. It then emits a one-cycle event to start transmission. The busy flag stays up until the transmitter signals that it is done. The converter, the FIFOs and the serial link are outside this block.

Top module: `strip_readout_seq`

## Requirements
- R1: After reset, busy_o, event_o, fe_clk_o, fe_shift_o and fifo_we_o are all low.
- R2: While xmit_busy_i is high, no trigger pair is accepted and busy_o stays low.
- R3: trig_first_ni is qualified only when it reads low for FILT_LEN (4) consecutive synchronized samples. A low lasting 3 clock cycles is rejected, and a low lasting exactly 4 cycles is accepted.
- R4: After a qualified first trigger, trig_second_i high within TIMEOUT_CYC (400) cycles starts readout and raises busy_o.
- R5: If trig_second_i stays low for the whole window, the block re-arms. A later second trigger without a new first trigger is ignored.
- R6: During readout, fe_clk_o gives NUM_CHAN (768) pulses with a period of 16 cycles. Each pulse is high for the first 8 cycles of its period and starts in the first cycle that busy_o is high.
- R7: fe_shift_o is high only during the first readout period (16 cycles), and it rises together with fe_clk_o.
- R8: fifo_we_o gives exactly NUM_CHAN single-cycle pulses, 16 cycles apart. The first pulse comes 16*ADC_LAT+15 cycles (63) after busy_o rises.
- R9: event_o is a single-cycle pulse. It appears 2 cycles after the last FIFO write when bus_busy_i is low, and it is held off for as long as bus_busy_i is high.
- R10: busy_o stays high through and after event_o until xmit_done_i is seen. It then drops one cycle later, and the block accepts a new trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| xmit_busy_i | input | 1 | Transmitter still sending the previous record |
| trig_first_ni | input | 1 | First-level trigger, active low, asynchronous |
| trig_second_i | input | 1 | Second-level trigger, active high, asynchronous |
| bus_busy_i | input | 1 | Downstream bus occupied; holds off the event |
| xmit_done_i | input | 1 | Transmitter finished the record; clears busy |
| fe_clk_o | output | 1 | Readout clock to all strings |
| fe_shift_o | output | 1 | Shift-in token for the first channel |
| fifo_we_o | output | 1 | FIFO write strobe, one per digitized channel |
| busy_o | output | 1 | Second trigger accepted, record in progress |
| event_o | output | 1 | One-cycle start pulse for the transmitter |

## Verification
The bench first drives a 3-cycle low on the first trigger and then a 4-cycle low. The 3-cycle low must be rejected and the 4-cycle low accepted. A filter that is off by one sample either starts on noise or misses a minimal trigger.

It lets the second-trigger window expire before raising the second trigger. A design without the re-arm would start a readout from a stale first trigger.

It measures the offset of the first and last FIFO write and counts every clock and write. A wrong latency pipe shifts or drops samples at one end of the record.

It holds the bus busy long after the last write, and it pulses transmit-done only late. A design that ignored either interlock would emit the event early or drop busy too soon.

// File: rtl/strip_seq_pkg.sv
package strip_seq_pkg;
  typedef enum logic [2:0] {
    ST_WAIT_XMT,
    ST_WAIT_L1,
    ST_WAIT_L2,
    ST_READ,
    ST_DRAIN,
    ST_DONE,
    ST_HOLD
  } seq_state_e;
endpackage

// File: rtl/trig_cond.sv
// Synchronizes both trigger lines; qualifies the active-low first trigger.
module trig_cond #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic first_ni,
  input  logic second_i,
  output logic first_ok_o,
  output logic second_o
);
  localparam int CW = $clog2(FILT_LEN + 1);
  localparam logic [CW-1:0] CNT_MAX  = CW'(FILT_LEN);
  localparam logic [CW-1:0] CNT_FIRE = CW'(FILT_LEN - 1);

  logic [SYNC_STAGES-1:0] first_sync_q, second_sync_q;
  logic [CW-1:0]          low_cnt_q;
  logic                   first_low;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      first_sync_q  <= '1;
      second_sync_q <= '0;
    end else begin
      first_sync_q[0]  <= first_ni;
      second_sync_q[0] <= second_i;
      for (int i = 1; i < SYNC_STAGES; i++) begin
        first_sync_q[i]  <= first_sync_q[i-1];
        second_sync_q[i] <= second_sync_q[i-1];
      end
    end
  end

  assign first_low = ~first_sync_q[SYNC_STAGES-1];
  assign second_o  = second_sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                low_cnt_q <= '0;
    else if (!first_low)        low_cnt_q <= '0;
    else if (low_cnt_q != CNT_MAX) low_cnt_q <= low_cnt_q + 1'b1;
  end

  // one-cycle pulse on the sample that completes the qualifying run
  assign first_ok_o = first_low && (low_cnt_q == CNT_FIRE);
endmodule

// File: rtl/tick_gen.sv
module tick_gen #(
  parameter int DIV = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic tick_o,
  output logic phase_hi_o
);
  localparam int DW = $clog2(DIV);
  localparam logic [DW-1:0] DIV_LAST = DW'(DIV - 1);
  localparam logic [DW-1:0] DIV_HALF = DW'(DIV / 2);

  logic [DW-1:0] div_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               div_q <= '0;
    else if (!en_i)            div_q <= '0;
    else if (div_q == DIV_LAST) div_q <= '0;
    else                       div_q <= div_q + 1'b1;
  end

  assign tick_o     = en_i && (div_q == DIV_LAST);
  assign phase_hi_o = en_i && (div_q < DIV_HALF);
endmodule

// File: rtl/lat_pipe.sv
// Delays the per-channel sample marker by LAT readout periods.
module lat_pipe #(
  parameter int LAT = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic push_i,
  output logic we_o,
  output logic last_o
);
  logic [LAT-1:0] pipe_q;
  logic           rest_busy;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pipe_q <= '0;
    else if (tick_i) begin
      if (LAT > 1) pipe_q <= {pipe_q[LAT-2:0], push_i};
      else         pipe_q[0] <= push_i;
    end
  end

  generate
    if (LAT > 1) begin : g_deep
      assign rest_busy = |pipe_q[LAT-2:0];
    end else begin : g_single
      assign rest_busy = 1'b0;
    end
  endgenerate

  assign we_o   = tick_i && pipe_q[LAT-1];
  assign last_o = tick_i && !rest_busy;
endmodule

// File: rtl/strip_readout_seq.sv
module strip_readout_seq
  import strip_seq_pkg::*;
#(
  parameter int NUM_CHAN    = 768,
  parameter int CLK_DIV     = 16,
  parameter int TIMEOUT_CYC = 400,
  parameter int FILT_LEN    = 4,
  parameter int SYNC_STAGES = 2,
  parameter int ADC_LAT     = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic xmit_busy_i,
  input  logic trig_first_ni,
  input  logic trig_second_i,
  input  logic bus_busy_i,
  input  logic xmit_done_i,
  output logic fe_clk_o,
  output logic fe_shift_o,
  output logic fifo_we_o,
  output logic busy_o,
  output logic event_o
);
  localparam int CHW = $clog2(NUM_CHAN);
  localparam int TMW = $clog2(TIMEOUT_CYC);
  localparam logic [CHW-1:0] CHAN_LAST = CHW'(NUM_CHAN - 1);
  localparam logic [TMW-1:0] TMO_LAST  = TMW'(TIMEOUT_CYC - 1);

  seq_state_e     state_q;
  logic [CHW-1:0] chan_q;
  logic [TMW-1:0] timer_q;
  logic           busy_q, event_q;
  logic           first_ok, second_s;
  logic           rd_en, tick, phase_hi, push, drain_last;

  trig_cond #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) u_trig (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .first_ni  (trig_first_ni),
    .second_i  (trig_second_i),
    .first_ok_o(first_ok),
    .second_o  (second_s)
  );

  assign rd_en = (state_q == ST_READ) || (state_q == ST_DRAIN);

  tick_gen #(.DIV(CLK_DIV)) u_tick (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (rd_en),
    .tick_o    (tick),
    .phase_hi_o(phase_hi)
  );

  assign push = (state_q == ST_READ) && tick;

  lat_pipe #(.LAT(ADC_LAT)) u_pipe (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_i(tick),
    .push_i(push),
    .we_o  (fifo_we_o),
    .last_o(drain_last)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_WAIT_XMT;
      chan_q  <= '0;
      timer_q <= '0;
      busy_q  <= 1'b0;
      event_q <= 1'b0;
    end else begin
      event_q <= 1'b0;
      case (state_q)
        ST_WAIT_XMT: if (!xmit_busy_i) state_q <= ST_WAIT_L1;
        ST_WAIT_L1: begin
          if (xmit_busy_i) state_q <= ST_WAIT_XMT;
          else if (first_ok) begin
            state_q <= ST_WAIT_L2;
            timer_q <= '0;
          end
        end
        ST_WAIT_L2: begin
          if (second_s) begin
            state_q <= ST_READ;
            busy_q  <= 1'b1;
            chan_q  <= '0;
          end else if (timer_q == TMO_LAST) begin
            state_q <= ST_WAIT_L1;  // window expired: re-arm
          end else begin
            timer_q <= timer_q + 1'b1;
          end
        end
        ST_READ: if (tick) begin
          if (chan_q == CHAN_LAST) state_q <= ST_DRAIN;
          else                     chan_q  <= chan_q + 1'b1;
        end
        ST_DRAIN: if (drain_last) state_q <= ST_DONE;
        ST_DONE: if (!bus_busy_i) begin
          event_q <= 1'b1;
          state_q <= ST_HOLD;
        end
        ST_HOLD: if (xmit_done_i) begin
          busy_q  <= 1'b0;
          state_q <= ST_WAIT_XMT;
        end
        default: state_q <= ST_WAIT_XMT;
      endcase
    end
  end

  assign fe_clk_o   = (state_q == ST_READ) && phase_hi;
  assign fe_shift_o = (state_q == ST_READ) && (chan_q == '0);
  assign busy_o     = busy_q;
  assign event_o    = event_q;
endmodule

// File: rtl/strip_seq_chk.sv
module strip_seq_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic bus_busy_i,
  input logic xmit_done_i,
  input logic fe_clk_o,
  input logic fe_shift_o,
  input logic fifo_we_o,
  input logic busy_o,
  input logic event_o
);
  AST_EVENT_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    event_o |=> !event_o); // R9
  AST_EVENT_BUS_FREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(event_o) |-> $past(!bus_busy_i)); // R9
  AST_EVENT_IN_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    event_o |-> busy_o); // R10
  AST_BUSY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !xmit_done_i) |=> busy_o); // R10
  AST_WE_IN_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_we_o |-> busy_o); // R8
  AST_WE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_we_o |=> !fifo_we_o); // R8
  AST_FECLK_IN_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fe_clk_o |-> busy_o); // R6
  AST_SHIFT_WITH_CLK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fe_shift_o) |-> fe_clk_o); // R7
endmodule

bind strip_readout_seq strip_seq_chk u_chk (.*);

// File: tb/tb_strip_readout_seq.sv
module tb_strip_readout_seq;
  localparam int CLK_PERIOD = 25;
  localparam int NCH = 768;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic xmit_busy = 1'b0, trig1_n = 1'b1, trig2 = 1'b0;
  logic bus_busy = 1'b0, xmit_done = 1'b0;
  logic fe_clk, fe_shift, fifo_we, busy, evt;

  int n_chk = 0, n_bad = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  strip_readout_seq dut (
    .clk_i(clk), .rst_ni(rst_n), .xmit_busy_i(xmit_busy),
    .trig_first_ni(trig1_n), .trig_second_i(trig2),
    .bus_busy_i(bus_busy), .xmit_done_i(xmit_done),
    .fe_clk_o(fe_clk), .fe_shift_o(fe_shift), .fifo_we_o(fifo_we),
    .busy_o(busy), .event_o(evt)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_l1(input int len);
    trig1_n = 1'b0; cyc(len); trig1_n = 1'b1;
  endtask

  task automatic t_reset;
    cyc(3);
    chk({busy, evt, fe_clk, fe_shift, fifo_we} == 5'b0, "R1 outputs idle in reset",
        int'({busy, evt, fe_clk, fe_shift, fifo_we}), 0);
    rst_n = 1'b1;
    cyc(3);
    chk({busy, evt, fe_clk, fe_shift, fifo_we} == 5'b0, "R1 outputs idle after reset",
        int'({busy, evt, fe_clk, fe_shift, fifo_we}), 0);
  endtask

  task automatic t_xmit_gate;
    int seen = 0;
    xmit_busy = 1'b1;
    cyc(2);
    pulse_l1(6);
    cyc(5);
    trig2 = 1'b1;
    for (int i = 0; i < 30; i++) begin cyc(1); if (busy) seen++; end
    trig2 = 1'b0;
    chk(seen == 0, "R2 trigger ignored while transmitter busy", seen, 0);
    xmit_busy = 1'b0;
    cyc(10);
  endtask

  task automatic t_glitch;
    int seen = 0;
    pulse_l1(3);
    cyc(3);
    trig2 = 1'b1;
    for (int i = 0; i < 30; i++) begin cyc(1); if (busy) seen++; end
    trig2 = 1'b0;
    chk(seen == 0, "R3 three-cycle low rejected", seen, 0);
    cyc(10);
  endtask

  task automatic t_timeout;
    int seen = 0;
    pulse_l1(4);   // minimal accepted length
    cyc(460);
    trig2 = 1'b1;
    for (int i = 0; i < 30; i++) begin cyc(1); if (busy) seen++; end
    trig2 = 1'b0;
    chk(seen == 0, "R5 second trigger after window ignored", seen, 0);
    cyc(10);
  endtask

  // start a record; returns with busy just observed high (cycle 0 of readout)
  task automatic start_record(input int l1_len, output bit ok);
    ok = 1'b0;
    pulse_l1(l1_len);
    cyc(50);
    trig2 = 1'b1;
    for (int i = 0; i < 20; i++) begin
      cyc(1);
      if (busy) begin ok = 1'b1; break; end
    end
    trig2 = 1'b0;
  endtask

  task automatic t_full(input int l1_len, input string tag);
    bit ok;
    int n = 0, clk_rise = 0, clk_hi = 0, shift_hi = 0, shift_late = 0;
    int we_cnt = 0, first_we = -1, last_we = -1, bad_gap = 0, ev_n = -1, ev_cnt = 0;
    bit prev_clk = 1'b0;
    start_record(l1_len, ok);
    chk(ok, tag, int'(busy), 1);
    chk(fe_clk && fe_shift, "R7 shift rises with first readout clock",
        int'({fe_clk, fe_shift}), 3);
    while (n < 13000 && ev_n < 0) begin
      if (fe_clk && !prev_clk) clk_rise++;
      if (fe_clk) clk_hi++;
      if (fe_shift) begin shift_hi++; if (n >= 16) shift_late++; end
      if (fifo_we) begin
        if (first_we < 0) first_we = n;
        else if (n - last_we != 16) bad_gap++;
        last_we = n; we_cnt++;
      end
      if (evt) begin ev_n = n; ev_cnt++; end
      prev_clk = fe_clk;
      cyc(1); n++;
    end
    chk(clk_rise == NCH, "R6 readout clock pulse count", clk_rise, NCH);
    chk(clk_hi == NCH * 8, "R6 readout clock high time", clk_hi, NCH * 8);
    chk(shift_hi == 16 && shift_late == 0, "R7 shift token first period only", shift_hi, 16);
    chk(we_cnt == NCH, "R8 FIFO write count", we_cnt, NCH);
    chk(first_we == 63, "R8 first write offset", first_we, 63);
    chk(bad_gap == 0, "R8 write spacing", bad_gap, 0);
    chk(ev_n - last_we == 2, "R9 event after last write", ev_n - last_we, 2);
    cyc(1);
    chk(!evt, "R9 event single cycle", int'(evt), 0);
    cyc(10);
    chk(busy, "R10 busy held until transmit done", int'(busy), 1);
    xmit_done = 1'b1; cyc(1); xmit_done = 1'b0;
    cyc(1);
    chk(!busy, "R10 busy cleared after transmit done", int'(busy), 0);
    cyc(5);
  endtask

  task automatic t_bus_hold;
    bit ok;
    int we_cnt = 0, ev_early = 0, ev_after = 0, guard = 0;
    bus_busy = 1'b1;
    start_record(6, ok);
    chk(ok, "R4 record started for bus hold", int'(busy), 1);
    while (we_cnt < NCH && guard < 13000) begin
      if (fifo_we) we_cnt++;
      if (evt) ev_early++;
      cyc(1); guard++;
    end
    for (int i = 0; i < 100; i++) begin if (evt) ev_early++; cyc(1); end
    chk(ev_early == 0, "R9 event held off while bus busy", ev_early, 0);
    bus_busy = 1'b0;
    cyc(1);
    chk(evt, "R9 event one cycle after bus frees", int'(evt), 1);
    for (int i = 0; i < 10; i++) begin cyc(1); if (evt) ev_after++; end
    chk(ev_after == 0, "R9 event not repeated", ev_after, 0);
    xmit_done = 1'b1; cyc(1); xmit_done = 1'b0;
    cyc(2);
    chk(!busy, "R10 busy cleared after bus-hold record", int'(busy), 0);
  endtask

  initial begin
    t_reset();
    t_xmit_gate();
    t_glitch();
    t_timeout();
    t_full(6, "R4 second trigger starts readout");
    t_full(4, "R3 four-cycle low accepted after previous record");
    t_bus_hold();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule